// File: doc/BRIEF.md
# Segment Translation Unit with Descriptor Cache

This block turns a logical address, made of a segment register number and a 32-bit offset, into a 32-bit linear address. It holds six segment registers. Software-visible loads place a 16-bit selector into one of them. The unit then fetches the matching 8-byte descriptor from a global or a local descriptor table through a simple memory read port, and keeps that descriptor in a cache entry beside the register. The selector carries a 13-bit table index, a table-choice bit and two protection bits.

Every access names a register and an offset. The unit compares the offset with the cached limit, which is stored as the highest legal byte offset. If the offset is legal, it adds the cached base. If the offset is out of range, or the register holds no valid descriptor, it reports a fault in place of an address. Ordinary accesses never touch memory. While a descriptor fetch is running, both the load port and the access port are held off by their ready signals.

Top module: `seg_xlate`

## Requirements
- R1: The selector is decoded as index = sel[15:3], table choice = sel[2] (1 = local table, 0 = global table) and protection = sel[1:0]. The descriptor address is the chosen table base input plus index × 8.
- R2: A non-null load issues exactly two 32-bit reads. The first is at the descriptor address and returns the base. The second is at the descriptor address + 4 and returns the limit. mem_req and mem_addr stay steady until mem_ack, which is sampled on the clock edge, and the load completes only after the second word arrives.
- R3: While a descriptor fetch is in progress, ld_ready and acc_ready are both low.
- R4: An access accepted on a clock edge to a valid register with offset ≤ limit gives rsp_valid=1 after that edge, with rsp_fault=0 and rsp_addr = base + offset modulo 2^32.
- R5: An access with offset > limit gives rsp_fault=1 and rsp_addr=0.
- R6: An access to a register that was never loaded, or whose descriptor is invalid, or whose number is 6 or 7, gives rsp_fault=1.
- R7: A selector with index 0 and table bit 0 is null. Loading it issues no memory read, completes in the accepting cycle so ld_ready stays high, and leaves the register invalid. Index 0 with table bit 1 is an ordinary local load.
- R8: Accesses perform no memory reads. Each register keeps its own descriptor, so a load into one register does not change translations through another.
- R9: rsp_prot returns the protection bits of the selector last loaded into the named register when the access does not fault, and 0 when it faults.
- R10: After reset every register is invalid, mem_req and rsp_valid are low, and ld_ready and acc_ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gdt_base | input | 32 | Base address of the global descriptor table |
| ldt_base | input | 32 | Base address of the local descriptor table |
| ld_valid | input | 1 | Load request |
| ld_reg | input | 3 | Segment register to load |
| ld_sel | input | 16 | Selector to load |
| ld_ready | output | 1 | Load can be accepted |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Read data |
| acc_valid | input | 1 | Access request |
| acc_reg | input | 3 | Segment register named by the access |
| acc_off | input | 32 | Offset within the segment |
| acc_ready | output | 1 | Access can be accepted |
| rsp_valid | output | 1 | Translation result valid |
| rsp_fault | output | 1 | Access faulted |
| rsp_addr | output | 32 | Linear address, 0 on a fault |
| rsp_prot | output | 2 | Protection bits of the used selector |

## Verification
The hardest situation to reach is the stall window. A fetch is in flight there, and the bench must show that both ready signals fall and that the request address holds still across slow memory. The bench's memory model inserts a chosen number of wait cycles before each acknowledge, and it checks the stall while mem_req is high. The limit boundary and modulo-2^32 wrap are reached by giving one table slot a base near the top of the address space and a limit of all ones. Null and local-index-0 selectors are loaded back to back, and the memory read count is compared.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int AW    = 32;
    localparam int SEL_W = 16;
    localparam int IDX_W = 13;
    localparam int DESC_SHIFT = 3;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
    } seg_desc_t;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_LO   = 2'd1,
        F_HI   = 2'd2
    } fetch_st_e;
endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
    import seg_xlate_pkg::*;
#(
    parameter int REG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] start_reg,
    input  logic [SEL_W-1:0] start_sel,
    input  logic [AW-1:0]    gdt_base,
    input  logic [AW-1:0]    ldt_base,
    output logic             busy,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic [AW-1:0]    mem_rdata,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_reg,
    output seg_desc_t        wr_desc
);
    localparam int PAD_W = AW - IDX_W - DESC_SHIFT;

    typedef struct packed {
        fetch_st_e        st;
        logic [AW-1:0]    addr;
        logic [AW-1:0]    base;
        logic [REG_W-1:0] tgt;
    } fstate_t;

    fstate_t q, d;
    logic    is_null;
    logic [AW-1:0] tbl_base;
    logic [AW-1:0] slot_off;

    assign is_null  = (start_sel[SEL_W-1:DESC_SHIFT] == '0) && !start_sel[2];
    assign tbl_base = start_sel[2] ? ldt_base : gdt_base;
    assign slot_off = {{PAD_W{1'b0}}, start_sel[SEL_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_reg  = q.tgt;
        wr_desc = '0;
        case (q.st)
            F_IDLE: begin
                if (start) begin
                    if (is_null) begin
                        wr_en  = 1'b1;
                        wr_reg = start_reg;
                    end else begin
                        d.st   = F_LO;
                        d.addr = tbl_base + slot_off;
                        d.tgt  = start_reg;
                    end
                end
            end
            F_LO: begin
                if (mem_ack) begin
                    d.base = mem_rdata;
                    d.addr = q.addr + AW'(4);
                    d.st   = F_HI;
                end
            end
            F_HI: begin
                if (mem_ack) begin
                    wr_en   = 1'b1;
                    wr_desc = '{valid: 1'b1, base: q.base, limit: mem_rdata};
                    d.st    = F_IDLE;
                end
            end
            default: d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.st != F_IDLE);
    assign mem_req  = busy;
    assign mem_addr = q.addr;

    // R2: request and address held until acknowledged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R2: after the first word arrives, the request moves to the next word
    p_second_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == F_LO && mem_ack) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(4)));
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
    import seg_xlate_pkg::*;
(
    input  seg_desc_t     desc,
    input  logic [AW-1:0] off,
    output logic          fault,
    output logic [AW-1:0] lin
);
    always_comb begin
        fault = !desc.valid || (off > desc.limit);
        lin   = fault ? '0 : desc.base + off;
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter  int NSEG  = 6,
    localparam int REG_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    gdt_base,
    input  logic [AW-1:0]    ldt_base,
    input  logic             ld_valid,
    input  logic [REG_W-1:0] ld_reg,
    input  logic [SEL_W-1:0] ld_sel,
    output logic             ld_ready,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic [AW-1:0]    mem_rdata,
    input  logic             acc_valid,
    input  logic [REG_W-1:0] acc_reg,
    input  logic [AW-1:0]    acc_off,
    output logic             acc_ready,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [AW-1:0]    rsp_addr,
    output logic [1:0]       rsp_prot
);
    typedef struct packed {
        seg_desc_t [NSEG-1:0] cache;
        logic [NSEG-1:0][1:0] prot;
        logic                 rsp_valid;
        logic                 rsp_fault;
        logic [AW-1:0]        rsp_addr;
        logic [1:0]           rsp_prot;
    } tstate_t;

    tstate_t q, d;

    logic             busy;
    logic             ld_fire, acc_fire, fetch_start;
    logic             wr_en;
    logic [REG_W-1:0] wr_reg;
    seg_desc_t        wr_desc;
    seg_desc_t        sel_desc;
    logic [1:0]       sel_prot;
    logic             chk_fault;
    logic [AW-1:0]    chk_lin;

    assign ld_ready    = !busy;
    assign acc_ready   = !busy;
    assign ld_fire     = ld_valid && ld_ready;
    assign acc_fire    = acc_valid && acc_ready;
    assign fetch_start = ld_fire && (int'(ld_reg) < NSEG);

    seg_desc_fetch #(.REG_W(REG_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fetch_start),
        .start_reg (ld_reg),
        .start_sel (ld_sel),
        .gdt_base  (gdt_base),
        .ldt_base  (ldt_base),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .wr_en     (wr_en),
        .wr_reg    (wr_reg),
        .wr_desc   (wr_desc)
    );

    always_comb begin
        sel_desc = '0;
        sel_prot = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (acc_reg == REG_W'(i)) begin
                sel_desc = q.cache[i];
                sel_prot = q.prot[i];
            end
        end
    end

    seg_limit_check u_check (
        .desc  (sel_desc),
        .off   (acc_off),
        .fault (chk_fault),
        .lin   (chk_lin)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = acc_fire;
        if (acc_fire) begin
            d.rsp_fault = chk_fault;
            d.rsp_addr  = chk_lin;
            d.rsp_prot  = chk_fault ? 2'b00 : sel_prot;
        end
        for (int i = 0; i < NSEG; i++) begin
            if (fetch_start && ld_reg == REG_W'(i)) d.prot[i]  = ld_sel[1:0];
            if (wr_en && wr_reg == REG_W'(i))       d.cache[i] = wr_desc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid = q.rsp_valid;
    assign rsp_fault = q.rsp_fault;
    assign rsp_addr  = q.rsp_addr;
    assign rsp_prot  = q.rsp_prot;

    // R3: both ports stall during a fetch
    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!acc_ready && !ld_ready));

    // R7: a null selector starts no memory read
    p_null_noread_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready && ld_sel[SEL_W-1:2] == '0) |=> !mem_req);

    // R4: a response appears only after an accepted access
    p_rsp_after_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc_valid && acc_ready));

    // R5: a faulted response carries no address
    p_fault_noaddr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_addr == '0 && rsp_prot == 2'b00));
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] GDT_B = 32'h0001_0000;
    localparam logic [31:0] LDT_B = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0, acc_valid = 1'b0;
    logic [2:0]  ld_reg = '0, acc_reg = '0;
    logic [15:0] ld_sel = '0;
    logic [31:0] acc_off = '0;
    logic        ld_ready, acc_ready, mem_req, mem_ack;
    logic [31:0] mem_addr, mem_rdata;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_prot;

    int tests = 0, fails = 0;
    int wait_cyc = 0, ack_cnt = 0, reads = 0;
    logic [31:0] rd_log [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst_n(rst_n), .gdt_base(GDT_B), .ldt_base(LDT_B),
        .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_sel(ld_sel), .ld_ready(ld_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .acc_valid(acc_valid), .acc_reg(acc_reg), .acc_off(acc_off), .acc_ready(acc_ready),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr), .rsp_prot(rsp_prot)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a == LDT_B + 32'd40) return 32'hFFFF_FF00;
        if (a == LDT_B + 32'd44) return 32'hFFFF_FFFF;
        if (a[2]) return {20'h0, a[14:3]} | 32'h100;
        return a ^ 32'hA5A5_0000;
    endfunction

    function automatic logic [31:0] slot_addr(input logic [15:0] sel);
        return (sel[2] ? LDT_B : GDT_B) + {16'h0, sel[15:3], 3'b000};
    endfunction

    // memory model with programmable wait cycles
    always @(negedge clk) begin
        if (!rst_n || !mem_req) begin
            mem_ack = 1'b0;
            ack_cnt = 0;
        end else if (ack_cnt >= wait_cyc) begin
            mem_ack   = 1'b1;
            mem_rdata = mem_word(mem_addr);
            if (reads < 4) rd_log[reads] = mem_addr;
            reads++;
            ack_cnt = 0;
        end else begin
            mem_ack = 1'b0;
            ack_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [2:0] r, input logic [15:0] sel, input bit expect_stall);
        bit stall_seen = 0;
        @(negedge clk);
        ld_valid = 1'b1; ld_reg = r; ld_sel = sel;
        @(posedge clk); #1;
        ld_valid = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (mem_req && !stall_seen) begin
                stall_seen = 1;
                check(!acc_ready && !ld_ready, "R3 ports stalled during fetch",
                      {30'h0, acc_ready, ld_ready}, 32'h0);
            end
            if (ld_ready) break;
        end
        if (expect_stall)
            check(stall_seen, "R2 fetch observed", 32'(stall_seen), 32'h1);
    endtask

    task automatic do_access(input logic [2:0] r, input logic [31:0] off, input bit exp_fault,
                             input logic [31:0] exp_addr, input logic [1:0] exp_prot, input string tag);
        int rd0 = reads;
        @(negedge clk);
        acc_valid = 1'b1; acc_reg = r; acc_off = off;
        @(posedge clk); #1;
        acc_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid, {tag, " rsp_valid"}, 32'(rsp_valid), 32'h1);
        check(rsp_fault == exp_fault, {tag, " fault"}, 32'(rsp_fault), 32'(exp_fault));
        check(rsp_addr == exp_addr, {tag, " address"}, rsp_addr, exp_addr);
        check(rsp_prot == exp_prot, {tag, " R9 prot"}, 32'(rsp_prot), 32'(exp_prot));
        check(reads == rd0, "R8 access made no memory read", 32'(reads - rd0), 32'h0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(!rsp_valid && !mem_req, "R10 outputs idle after reset", {30'h0, rsp_valid, mem_req}, 32'h0);
        check(ld_ready && acc_ready, "R10 ready after reset", {30'h0, ld_ready, acc_ready}, 32'h3);
        do_access(3'd0, 32'h0, 1'b1, 32'h0, 2'b00, "R10 R6 reg0 invalid after reset");
    endtask

    task automatic t_global_load;
        logic [15:0] sel = {13'd3, 1'b0, 2'b01};
        logic [31:0] a = slot_addr(sel);
        logic [31:0] b = mem_word(a), l = mem_word(a + 4);
        wait_cyc = 0; reads = 0;
        do_load(3'd1, sel, 1'b1);
        check(reads == 2, "R2 two reads per load", 32'(reads), 32'h2);
        check(rd_log[0] == a, "R1 first read at table base + index*8", rd_log[0], a);
        check(rd_log[1] == a + 4, "R2 second read at +4", rd_log[1], a + 4);
        do_access(3'd1, 32'h10, 1'b0, b + 32'h10, 2'b01, "R4 in range");
        do_access(3'd1, l, 1'b0, b + l, 2'b01, "R4 offset equal to limit");
        do_access(3'd1, l + 1, 1'b1, 32'h0, 2'b00, "R5 offset above limit");
    endtask

    task automatic t_local_slow;
        logic [15:0] sel = {13'd7, 1'b1, 2'b11};
        logic [31:0] a = slot_addr(sel);
        wait_cyc = 2; reads = 0;
        do_load(3'd2, sel, 1'b1);
        check(reads == 2, "R2 two reads with wait states", 32'(reads), 32'h2);
        check(rd_log[0] == a, "R1 local table read address", rd_log[0], a);
        do_access(3'd2, 32'h5, 1'b0, mem_word(a) + 32'h5, 2'b11, "R4 local segment");
        wait_cyc = 0;
    endtask

    task automatic t_bad_regs;
        do_access(3'd7, 32'h0, 1'b1, 32'h0, 2'b00, "R6 register number 7");
        do_access(3'd5, 32'h0, 1'b1, 32'h0, 2'b00, "R6 register never loaded");
    endtask

    task automatic t_null;
        reads = 0;
        @(negedge clk);
        ld_valid = 1'b1; ld_reg = 3'd1; ld_sel = 16'h0002;
        @(posedge clk); #1;
        ld_valid = 1'b0;
        @(negedge clk);
        check(ld_ready && !mem_req, "R7 null load finishes without fetch", {30'h0, ld_ready, mem_req}, 32'h2);
        check(reads == 0, "R7 null load reads nothing", 32'(reads), 32'h0);
        do_access(3'd1, 32'h0, 1'b1, 32'h0, 2'b00, "R7 nulled register faults");
        reads = 0;
        do_load(3'd3, 16'h0004, 1'b1);
        check(reads == 2 && rd_log[0] == LDT_B, "R7 local index 0 is fetched", rd_log[0], LDT_B);
        do_access(3'd3, 32'h0, 1'b0, mem_word(LDT_B), 2'b00, "R7 local index 0 usable");
    endtask

    task automatic t_wrap;
        do_load(3'd4, {13'd5, 1'b1, 2'b10}, 1'b1);
        do_access(3'd4, 32'h200, 1'b0, 32'h0000_0100, 2'b10, "R4 sum wraps modulo 2^32");
        do_access(3'd4, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FEFF, 2'b10, "R4 max offset with full limit");
        do_access(3'd2, 32'h5, 1'b0, mem_word(slot_addr({13'd7, 1'b1, 2'b11})) + 32'h5, 2'b11,
                  "R8 other register unchanged");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_global_load();
        t_local_slow();
        t_bad_regs();
        t_null();
        t_wrap();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule